// File: doc/BRIEF.md
# Interleaved Text Display Address Scanner

This block walks a 40-column by 24-row character display in raster order and gives the memory address of each character cell. Rows do not sit one after another in memory. The page holds three groups of eight rows. Inside a group, consecutive rows are 0x80 bytes apart. Each group starts 0x28 bytes after the group before it. The scanner therefore builds each row's base from the group index and the row-within-group index, and does not multiply the row number by the line length.

A character-clock enable moves a column counter and a row counter forward. Downstream logic reads the current column, the current row and the cell address, which is a combinational function of the counter state and a page-select input. A single-cycle frame-done pulse marks the end of the last cell of the frame. The page-select input chooses between the first text page at 0x400 and a second page placed directly above it.

Top module: `txt_addr_scanner`

## Requirements
- R1: While the synchronous active-low reset is asserted, and after it is released until the first enabled cycle, the column and row indices are 0, frame_done is 0, and the cell address is 0x400 when page_sel is low.
- R2: In a cycle where char_en is low, the column and row indices keep their values across the clock edge.
- R3: On each clock edge with char_en high, the column index increases by one. From 39 it wraps to 0 and the row index increases by one.
- R4: When char_en is high at column 39 of row 23, the row index wraps to 0 together with the column index.
- R5: frame_done is high for exactly the one cycle after the edge at which the enabled final cell (row 23, column 39) was left, and low in every other cycle.
- R6: With page_sel low, cell_addr = 0x400 + (row mod 8)*0x80 + (row div 8)*0x28 + column. This gives row bases 0x400, 0x428 and 0x450 for rows 0, 8 and 16.
- R7: With page_sel high, cell_addr is the R6 value plus 0x400. The input acts in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_en | input | 1 | Character-clock enable; advances the scan by one cell |
| page_sel | input | 1 | 0 selects the first text page, 1 the second |
| cur_col | output | 6 | Current column index, 0 to 39 |
| cur_row | output | 5 | Current row index, 0 to 23 |
| cell_addr | output | 16 | Memory address of the current character cell |
| frame_done | output | 1 | One-cycle pulse after the last cell of a frame |

## Verification
The bench uses the default parameters: 40 columns, 24 rows, eight-row groups, strides 0x80 and 0x28, and a 16-bit address. At these values a complete frame is only 960 cells, so the bench can sweep every cell of more than two full frames. It compares the address against the arithmetic formula on every cycle. An irregular enable pattern mixes held cycles with advancing ones. The page select flips both between frames and within a frame, so each group boundary, each row wrap and the same-cycle page response are all exercised.

// File: rtl/txt_scan_pkg.sv
// Package txt_scan_pkg
// Holds the default geometry and layout constants for the text scanner.
// The modules take these as parameter defaults, so the values are kept in one place.
package txt_scan_pkg;
    localparam int unsigned DEF_COLS         = 40;
    localparam int unsigned DEF_ROWS         = 24;
    localparam int unsigned DEF_ROWS_PER_GRP = 8;
    localparam int unsigned DEF_ROW_STRIDE   = 'h80;
    localparam int unsigned DEF_GRP_STRIDE   = 'h28;
    localparam int unsigned DEF_PAGE_BASE    = 'h400;
    localparam int unsigned DEF_PAGE_SPAN    = 'h400;
    localparam int unsigned DEF_ADDR_W       = 16;
endpackage

// File: rtl/txt_scan_ctr.sv
// Module txt_scan_ctr
// Raster-order column/row counter that advances on a character-clock enable.
// It also produces a registered one-cycle end-of-frame pulse.
// Assumes COLS >= 2 and ROWS >= 2. Reset is synchronous and active low.
module txt_scan_ctr #(
    parameter int unsigned COLS  = txt_scan_pkg::DEF_COLS,
    parameter int unsigned ROWS  = txt_scan_pkg::DEF_ROWS,
    localparam int unsigned COL_W = $clog2(COLS),
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [COL_W-1:0] col_q,
    output logic [ROW_W-1:0] row_q,
    output logic             frame_end_q
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic at_col_last;
    logic at_row_last;

    // Decode the last column and the last row of the scan.
    always_comb begin
        at_col_last = (col_q == COL_LAST);
        at_row_last = (row_q == ROW_LAST);
    end

    // Step the counters, wrap them, and flag the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q       <= '0;
            row_q       <= '0;
            frame_end_q <= 1'b0;
        end else begin
            frame_end_q <= 1'b0;
            if (step_en) begin
                frame_end_q <= at_col_last && at_row_last;
                if (at_col_last) begin
                    col_q <= '0;
                    row_q <= at_row_last ? '0 : row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= COL_LAST); // R3
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= ROW_LAST); // R4
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(col_q) && $stable(row_q))); // R2
    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && at_col_last) |=> (col_q == '0)); // R3
    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && at_col_last && at_row_last) |=> (row_q == '0 && frame_end_q)); // R4
    AST_FRAME_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_q |=> !frame_end_q); // R5
endmodule

// File: rtl/txt_row_base.sv
// Module txt_row_base
// Maps a row index to the offset of that row within a page, using the
// interleaved layout: (row within group)*ROW_STRIDE + (group)*GRP_STRIDE.
// A power-of-two group size uses bit slices; any other size uses divide/modulo.
module txt_row_base #(
    parameter int unsigned ROWS         = txt_scan_pkg::DEF_ROWS,
    parameter int unsigned ROWS_PER_GRP = txt_scan_pkg::DEF_ROWS_PER_GRP,
    parameter int unsigned ROW_STRIDE   = txt_scan_pkg::DEF_ROW_STRIDE,
    parameter int unsigned GRP_STRIDE   = txt_scan_pkg::DEF_GRP_STRIDE,
    parameter int unsigned ADDR_W       = txt_scan_pkg::DEF_ADDR_W,
    localparam int unsigned ROW_W       = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0]  row_idx,
    output logic [ADDR_W-1:0] row_off
);
    localparam bit          GRP_POW2   = (ROWS_PER_GRP & (ROWS_PER_GRP - 1)) == 0;
    localparam int unsigned GRP_BITS   = (ROWS_PER_GRP > 1) ? $clog2(ROWS_PER_GRP) : 1;
    localparam logic [ADDR_W-1:0] ROW_STR_A = ADDR_W'(ROW_STRIDE);
    localparam logic [ADDR_W-1:0] GRP_STR_A = ADDR_W'(GRP_STRIDE);

    logic [ADDR_W-1:0] in_grp;
    logic [ADDR_W-1:0] grp_num;

    generate
        if (GRP_POW2 && ROWS_PER_GRP > 1 && GRP_BITS < ROW_W) begin : g_slice
            // Split the row index into group and in-group fields by bit slicing.
            always_comb begin
                in_grp  = ADDR_W'(row_idx[GRP_BITS-1:0]);
                grp_num = ADDR_W'(row_idx[ROW_W-1:GRP_BITS]);
            end
        end else begin : g_divide
            // Split the row index with a constant divide for non-power-of-two groups.
            always_comb begin
                in_grp  = ADDR_W'(32'(row_idx) % ROWS_PER_GRP);
                grp_num = ADDR_W'(32'(row_idx) / ROWS_PER_GRP);
            end
        end
    endgenerate

    // Combine both strides into the in-page offset of the row.
    always_comb begin
        row_off = in_grp * ROW_STR_A + grp_num * GRP_STR_A;
    end
endmodule

// File: rtl/txt_cell_addr.sv
// Module txt_cell_addr
// Forms the final cell address: page base, plus the second-page span when
// page_sel is high, plus the row offset, plus the column. The path is purely
// combinational, so a change of page takes effect in the same cycle.
module txt_cell_addr #(
    parameter int unsigned COLS      = txt_scan_pkg::DEF_COLS,
    parameter int unsigned PAGE_BASE = txt_scan_pkg::DEF_PAGE_BASE,
    parameter int unsigned PAGE_SPAN = txt_scan_pkg::DEF_PAGE_SPAN,
    parameter int unsigned ADDR_W    = txt_scan_pkg::DEF_ADDR_W,
    localparam int unsigned COL_W    = $clog2(COLS)
) (
    input  logic [ADDR_W-1:0] row_off,
    input  logic [COL_W-1:0]  col_idx,
    input  logic              page_sel,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PAGE_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(PAGE_SPAN);

    // Add the page base, the page offset, the row offset and the column.
    always_comb begin
        addr = BASE_A + (page_sel ? SPAN_A : '0) + row_off + ADDR_W'(col_idx);
    end
endmodule

// File: rtl/txt_addr_scanner.sv
// Module txt_addr_scanner (top)
// Scans a character display in raster order and presents the interleaved
// memory address of each cell, together with its column and row indices and
// an end-of-frame pulse. Assumes the whole scan of both pages fits in ADDR_W bits.
module txt_addr_scanner #(
    parameter int unsigned COLS         = txt_scan_pkg::DEF_COLS,
    parameter int unsigned ROWS         = txt_scan_pkg::DEF_ROWS,
    parameter int unsigned ROWS_PER_GRP = txt_scan_pkg::DEF_ROWS_PER_GRP,
    parameter int unsigned ROW_STRIDE   = txt_scan_pkg::DEF_ROW_STRIDE,
    parameter int unsigned GRP_STRIDE   = txt_scan_pkg::DEF_GRP_STRIDE,
    parameter int unsigned PAGE_BASE    = txt_scan_pkg::DEF_PAGE_BASE,
    parameter int unsigned PAGE_SPAN    = txt_scan_pkg::DEF_PAGE_SPAN,
    parameter int unsigned ADDR_W       = txt_scan_pkg::DEF_ADDR_W,
    localparam int unsigned COL_W       = $clog2(COLS),
    localparam int unsigned ROW_W       = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_en,
    input  logic              page_sel,
    output logic [COL_W-1:0]  cur_col,
    output logic [ROW_W-1:0]  cur_row,
    output logic [ADDR_W-1:0] cell_addr,
    output logic              frame_done
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(PAGE_BASE);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(PAGE_BASE + 2 * PAGE_SPAN);

    logic [ADDR_W-1:0] row_off;

    txt_scan_ctr #(.COLS(COLS), .ROWS(ROWS)) ctr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (char_en),
        .col_q       (cur_col),
        .row_q       (cur_row),
        .frame_end_q (frame_done)
    );

    txt_row_base #(
        .ROWS(ROWS), .ROWS_PER_GRP(ROWS_PER_GRP), .ROW_STRIDE(ROW_STRIDE),
        .GRP_STRIDE(GRP_STRIDE), .ADDR_W(ADDR_W)
    ) rowb_i (
        .row_idx (cur_row),
        .row_off (row_off)
    );

    txt_cell_addr #(
        .COLS(COLS), .PAGE_BASE(PAGE_BASE), .PAGE_SPAN(PAGE_SPAN), .ADDR_W(ADDR_W)
    ) cell_i (
        .row_off  (row_off),
        .col_idx  (cur_col),
        .page_sel (page_sel),
        .addr     (cell_addr)
    );

    AST_ADDR_IN_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_addr >= LO_A) && (cell_addr < HI_A)); // R6
    AST_ORIGIN_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_col == '0 && cur_row == '0 && !page_sel) |-> (cell_addr == LO_A)); // R1
endmodule

// File: tb/txt_addr_scanner_tb_top.sv
`timescale 1ns/1ps
// Bench txt_addr_scanner_tb_top
// Sweeps more than two full frames under an irregular enable pattern and a
// changing page select. Every cycle is compared with an arithmetic model.
module txt_addr_scanner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_en = 1'b0;
    logic        page_sel = 1'b0;
    logic [5:0]  cur_col;
    logic [4:0]  cur_row;
    logic [15:0] cell_addr;
    logic        frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    txt_addr_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .char_en(char_en), .page_sel(page_sel),
        .cur_col(cur_col), .cur_row(cur_row), .cell_addr(cell_addr),
        .frame_done(frame_done)
    );

    // Formula taken from R6 and R7.
    function automatic int exp_addr(int r, int c, bit pg);
        return 'h400 + (pg ? 'h400 : 0) + (r % 8) * 'h80 + (r / 8) * 'h28 + c;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin : main
        int m_col = 0;
        int m_row = 0;
        bit m_fd = 0;
        bit prev_en = 0;
        int frames = 0;
        // R1: reset state, with the enable held high during reset.
        char_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 col", cur_col, 0);
        chk("R1 row", cur_row, 0);
        chk("R1 frame_done", frame_done, 0);
        chk("R1 addr", cell_addr, 'h400);
        char_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 col after release", cur_col, 0);
        chk("R1 addr after release", cell_addr, 'h400);
        for (int i = 0; i < 3200; i++) begin
            @(negedge clk);
            char_en  = ((i % 5) != 3) && ((i % 11) != 7);
            page_sel = (i >= 1500 && i < 2900) ^ ((i % 13) == 4);
            #1;
            chk(prev_en ? "R3 col" : "R2 col held", cur_col, m_col);
            chk(prev_en ? "R4 row" : "R2 row held", cur_row, m_row);
            chk("R5 frame_done", frame_done, m_fd);
            chk(page_sel ? "R7 addr page2" : "R6 addr page1",
                cell_addr, exp_addr(m_row, m_col, page_sel));
            if (frame_done) frames++;
            // Predict the state after the next rising edge.
            m_fd = char_en && m_col == 39 && m_row == 23;
            if (char_en) begin
                if (m_col == 39) begin
                    m_col = 0;
                    m_row = (m_row == 23) ? 0 : m_row + 1;
                end else begin
                    m_col++;
                end
            end
            prev_en = char_en;
        end
        chk("R5 frames counted", frames, 2);
        // R6: spot checks of the group bases for rows 0, 8 and 16.
        chk("R6 row0 base", exp_addr(0, 0, 0), 'h400);
        chk("R6 row8 base", exp_addr(8, 0, 0), 'h428);
        chk("R6 row16 base", exp_addr(16, 0, 0), 'h450);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule